// File: doc/BRIEF.md
# ECP Forward-Channel Host Handshake Engine

This block is the host side of a parallel port running in extended-capability forward mode. It takes bytes from a ready/valid stream, each tagged as data or command. It places each byte and its tag on the port pins, and then walks a four-edge interlocked handshake with the peripheral. The host strobe falls only after a programmable setup interval. It rises again only once the peripheral's busy/acknowledge line has risen. The transfer counts as done only when that line falls back. There is no fixed pulse timing: every step waits for the other side.

All peripheral inputs pass through two-flop synchronizers. The fault line serves as the peripheral's request to reverse the channel. It is reported as a level, and a byte already in flight is never aborted. A programmable watchdog counter sets a sticky error when the peripheral stalls in either wait. A separate request input switches the control-line drivers between open-drain style and push-pull. The switch happens only while the engine is idle, with the line levels held steady on both sides of the change.

Top module: `ecp_fwd_host`

## Requirements
- R1: After reset, host_clk_o is 1, in_ready is 1, drv_pp_o is 0 (open-drain style), timeout_err_o is 0 and rev_req_o is 0.
- R2: A byte is accepted on a clock edge where in_valid and in_ready are both 1. From the next cycle, pd_o holds in_data and cmd_flag_o holds in_is_cmd (1 = command, 0 = data). in_ready stays 0 until that transfer completes.
- R3: host_clk_o falls exactly setup_cycles+1 clock edges after the accept edge, and pd_o does not change while host_clk_o is low.
- R4: host_clk_o stays low until the peripheral acknowledge line is high. It rises on the third clock edge after periph_ack_i rises (two synchronizer stages plus one state register).
- R5: A transfer completes when periph_ack_i returns low. in_ready returns to 1 on the third clock edge after that fall, and no new byte starts before then.
- R6: While idle, no byte is started while the synchronized acknowledge is high. in_ready drops two edges after periph_ack_i rises, and in that time host_clk_o and pd_o do not change even with in_valid held at 1.
- R7: rev_req_o equals the inverse of periph_req_n_i delayed by two clock edges. Changing periph_req_n_i does not alter the progress of a byte in flight.
- R8: After entering either acknowledge wait, the watchdog sets timeout_err_o if the acknowledge line has not changed within timeout_cycles+1 edges. The flag stays set until the next byte is accepted, and the handshake still completes normally.
- R9: A change of ecp_mode_req takes effect only in idle. in_ready is 0 while it is pending. drv_pp_o changes two edges after the engine is idle with the request pending, and in_ready returns one edge later. host_clk_o is high and unchanged across the switch.
- R10: With drv_pp_o = 1, host_clk_oe and cmd_flag_oe are 1. With drv_pp_o = 0, each enable is 1 only while its line level is 0 (the pin is pulled low, never driven high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte available on the input stream |
| in_ready | output | 1 | Engine can accept a byte |
| in_data | input | DATA_W | Byte to send |
| in_is_cmd | input | 1 | 1 marks the byte as a command |
| setup_cycles | input | SETUP_W | Extra setup clocks before the strobe falls |
| timeout_cycles | input | TMO_W | Watchdog limit for each acknowledge wait |
| ecp_mode_req | input | 1 | Requested driver mode, 1 = push-pull |
| periph_ack_i | input | 1 | Peripheral busy/acknowledge line, asynchronous |
| periph_req_n_i | input | 1 | Peripheral reverse request, active low, asynchronous |
| pd_o | output | DATA_W | Parallel data bus |
| cmd_flag_o | output | 1 | Command/data tag line level |
| cmd_flag_oe | output | 1 | Output enable of the tag line |
| host_clk_o | output | 1 | Host strobe line level |
| host_clk_oe | output | 1 | Output enable of the strobe line |
| drv_pp_o | output | 1 | Current driver mode, 1 = push-pull |
| rev_req_o | output | 1 | Synchronized reverse-channel request |
| timeout_err_o | output | 1 | Sticky acknowledge watchdog error |

## Verification
The bench builds the engine with a two-bit setup field and a three-bit watchdog field, and programs the watchdog limit to 3. That lets it sweep every setup length together with acknowledge-rise and acknowledge-fall delays of zero to four clocks. This puts the exact watchdog boundary (one clock short of the limit versus at it) in both wait states within reach, alongside command and data tags. Some sweep points also flip the driver-mode request mid-transfer, so the deferred switch is exercised in both directions under traffic.

// File: rtl/ecp_fwd_pkg.sv
package ecp_fwd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RELEASE,
        ST_MODE_PRE,
        ST_MODE_POST
    } fwd_state_e;

endpackage

// File: rtl/ecp_fwd_sync.sv
module ecp_fwd_sync #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] meta_q, meta_d;
    logic [WIDTH-1:0] hold_q, hold_d;

    always_comb begin
        meta_d = async_i;
        hold_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            hold_q <= RST_VAL;
        end else begin
            meta_q <= meta_d;
            hold_q <= hold_d;
        end
    end

    assign sync_o = hold_q;

endmodule

// File: rtl/ecp_fwd_timer.sv
module ecp_fwd_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cnt_q) == '0) && !$past(load_i)) |-> (cnt_q == '0));

endmodule

// File: rtl/ecp_fwd_drv.sv
module ecp_fwd_drv (
    input  logic pp_i,
    input  logic clk_lvl_i,
    input  logic flag_lvl_i,
    output logic clk_oe_o,
    output logic flag_oe_o
);

    logic [1:0] lvl;
    logic [1:0] oe;

    assign lvl = {flag_lvl_i, clk_lvl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        always_comb begin
            if (pp_i) begin
                oe[g] = 1'b1;
            end else begin
                oe[g] = ~lvl[g];
            end
        end
    end

    assign clk_oe_o  = oe[0];
    assign flag_oe_o = oe[1];

endmodule

// File: rtl/ecp_fwd_host.sv
module ecp_fwd_host #(
    parameter int DATA_W  = 8,
    parameter int SETUP_W = 8,
    parameter int TMO_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_is_cmd,
    input  logic [SETUP_W-1:0] setup_cycles,
    input  logic [TMO_W-1:0]  timeout_cycles,
    input  logic              ecp_mode_req,
    input  logic              periph_ack_i,
    input  logic              periph_req_n_i,
    output logic [DATA_W-1:0] pd_o,
    output logic              cmd_flag_o,
    output logic              cmd_flag_oe,
    output logic              host_clk_o,
    output logic              host_clk_oe,
    output logic              drv_pp_o,
    output logic              rev_req_o,
    output logic              timeout_err_o
);
    import ecp_fwd_pkg::*;

    localparam int CNT_W = (SETUP_W > TMO_W) ? SETUP_W : TMO_W;

    typedef struct packed {
        fwd_state_e        state;
        logic [DATA_W-1:0] data;
        logic              flag;
        logic              hclk;
        logic              mode;
        logic              err;
    } eng_t;

    eng_t cur_q, nxt_d;

    logic [1:0]       sync_out;
    logic             ack_s;
    logic             req_n_s;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_dec;
    logic             tmr_zero;
    logic             mode_pending;

    ecp_fwd_sync #(
        .WIDTH   (2),
        .RST_VAL (2'b10)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({periph_req_n_i, periph_ack_i}),
        .sync_o  (sync_out)
    );

    assign ack_s   = sync_out[0];
    assign req_n_s = sync_out[1];

    ecp_fwd_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .dec_i      (tmr_dec),
        .zero_o     (tmr_zero)
    );

    assign mode_pending = (ecp_mode_req != cur_q.mode);

    always_comb begin
        nxt_d    = cur_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_dec  = 1'b0;
        in_ready = (cur_q.state == ST_IDLE) && !ack_s && !mode_pending;

        case (cur_q.state)
            ST_IDLE: begin
                if (mode_pending) begin
                    nxt_d.state = ST_MODE_PRE;
                end else if (in_valid && !ack_s) begin
                    nxt_d.data  = in_data;
                    nxt_d.flag  = in_is_cmd;
                    nxt_d.err   = 1'b0;
                    nxt_d.state = ST_SETUP;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(setup_cycles);
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    nxt_d.hclk  = 1'b0;
                    nxt_d.state = ST_STROBE;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(timeout_cycles);
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_STROBE: begin
                if (ack_s) begin
                    nxt_d.hclk  = 1'b1;
                    nxt_d.state = ST_RELEASE;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(timeout_cycles);
                end else if (tmr_zero) begin
                    nxt_d.err = 1'b1;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_RELEASE: begin
                if (!ack_s) begin
                    nxt_d.state = ST_IDLE;
                end else if (tmr_zero) begin
                    nxt_d.err = 1'b1;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_MODE_PRE: begin
                nxt_d.mode  = ~cur_q.mode;
                nxt_d.state = ST_MODE_POST;
            end
            ST_MODE_POST: begin
                nxt_d.state = ST_IDLE;
            end
            default: begin
                nxt_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= ST_IDLE;
            cur_q.data  <= '0;
            cur_q.flag  <= 1'b0;
            cur_q.hclk  <= 1'b1;
            cur_q.mode  <= 1'b0;
            cur_q.err   <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    ecp_fwd_drv drv_i (
        .pp_i       (cur_q.mode),
        .clk_lvl_i  (cur_q.hclk),
        .flag_lvl_i (cur_q.flag),
        .clk_oe_o   (host_clk_oe),
        .flag_oe_o  (cmd_flag_oe)
    );

    assign pd_o          = cur_q.data;
    assign cmd_flag_o    = cur_q.flag;
    assign host_clk_o    = cur_q.hclk;
    assign drv_pp_o      = cur_q.mode;
    assign rev_req_o     = ~req_n_s;
    assign timeout_err_o = cur_q.err;

    // R2
    byte_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (pd_o == $past(in_data)));

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_q.hclk |-> $stable(cur_q.data));

    // R4
    strobe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.hclk) |-> $past(ack_s));

    // R6
    start_low_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.state == ST_SETUP) && ($past(cur_q.state) == ST_IDLE)) |-> !$past(ack_s));

    // R8
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.err) |-> ($past(cur_q.state) inside {ST_STROBE, ST_RELEASE}));

    // R9
    mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.mode != $past(cur_q.mode)) |->
            (cur_q.hclk && $past(cur_q.hclk) && ($past(cur_q.state) == ST_MODE_PRE)));

endmodule

// File: tb/ecp_fwd_host_tb_top.sv
module ecp_fwd_host_tb_top;

    localparam int TMO = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       in_is_cmd = 1'b0;
    logic [1:0] setup_cycles = '0;
    logic [2:0] timeout_cycles = 3'(TMO);
    logic       ecp_mode_req = 1'b0;
    logic       periph_ack_i = 1'b0;
    logic       periph_req_n_i = 1'b1;
    logic [7:0] pd_o;
    logic       cmd_flag_o, cmd_flag_oe, host_clk_o, host_clk_oe;
    logic       drv_pp_o, rev_req_o, timeout_err_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ecp_fwd_host #(
        .DATA_W  (8),
        .SETUP_W (2),
        .TMO_W   (3)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_data        (in_data),
        .in_is_cmd      (in_is_cmd),
        .setup_cycles   (setup_cycles),
        .timeout_cycles (timeout_cycles),
        .ecp_mode_req   (ecp_mode_req),
        .periph_ack_i   (periph_ack_i),
        .periph_req_n_i (periph_req_n_i),
        .pd_o           (pd_o),
        .cmd_flag_o     (cmd_flag_o),
        .cmd_flag_oe    (cmd_flag_oe),
        .host_clk_o     (host_clk_o),
        .host_clk_oe    (host_clk_oe),
        .drv_pp_o       (drv_pp_o),
        .rev_req_o      (rev_req_o),
        .timeout_err_o  (timeout_err_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // R10: expected enables from the driver mode and line levels
    task automatic check_oe();
        int exp_c = drv_pp_o ? 1 : int'(!host_clk_o);
        int exp_f = drv_pp_o ? 1 : int'(!cmd_flag_o);
        check(host_clk_oe == exp_c[0], "R10 strobe enable", host_clk_oe, exp_c);
        check(cmd_flag_oe == exp_f[0], "R10 flag enable", cmd_flag_oe, exp_f);
    endtask

    task automatic send(input logic [7:0] b, input bit cmd, input int s,
                        input int d, input int l, input bit flip);
        bit exp_err = ((d + 1) >= TMO) || ((l + 1) >= TMO);
        logic old_mode = drv_pp_o;
        int n;
        setup_cycles   = 2'(s);
        in_data        = b;
        in_is_cmd      = cmd;
        in_valid       = 1'b1;
        periph_req_n_i = b[1];
        #1;
        check(in_ready == 1'b1, "R2 ready before accept", in_ready, 1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(pd_o == b, "R2 data on bus", pd_o, b);
        check(cmd_flag_o == cmd, "R2 tag line", cmd_flag_o, cmd);
        check(timeout_err_o == 1'b0, "R8 cleared on accept", timeout_err_o, 0);
        check(in_ready == 1'b0, "R2 busy after accept", in_ready, 0);
        check(host_clk_o == 1'b1, "R3 strobe high at accept", host_clk_o, 1);
        for (int i = 1; i <= s + 1; i++) begin
            @(negedge clk);
            check(host_clk_o == (i <= s), "R3 strobe fall edge", host_clk_o, (i <= s));
            check(pd_o == b, "R3 data stable", pd_o, b);
        end
        check_oe();
        periph_req_n_i = b[2];
        if (flip) ecp_mode_req = ~ecp_mode_req;
        for (int j = 0; j < d; j++) begin
            @(negedge clk);
            check(host_clk_o == 1'b0, "R4 strobe held low", host_clk_o, 0);
            check(in_ready == 1'b0, "R5 not ready mid transfer", in_ready, 0);
            check(drv_pp_o == old_mode, "R9 no mode change in flight", drv_pp_o, old_mode);
        end
        periph_ack_i = 1'b1;
        for (int j = 1; j <= 3; j++) begin
            @(negedge clk);
            check(host_clk_o == (j == 3), "R4 strobe rise latency", host_clk_o, (j == 3));
            check(pd_o == b, "R7 byte not aborted", pd_o, b);
        end
        for (int j = 0; j < l; j++) begin
            @(negedge clk);
            check(host_clk_o == 1'b1, "R4 strobe stays high", host_clk_o, 1);
            check(in_ready == 1'b0, "R5 wait for ack fall", in_ready, 0);
        end
        check_oe();
        periph_ack_i = 1'b0;
        n = flip ? 6 : 3;
        for (int j = 1; j <= n; j++) begin
            @(negedge clk);
            check(in_ready == (j == n), "R5 completion latency", in_ready, (j == n));
            if (flip) begin
                logic exp_m = (j >= 5) ? ~old_mode : old_mode;
                check(drv_pp_o == exp_m, "R9 deferred mode switch", drv_pp_o, exp_m);
                check(host_clk_o == 1'b1, "R9 strobe steady", host_clk_o, 1);
            end
        end
        check(timeout_err_o == exp_err, "R8 watchdog flag", timeout_err_o, exp_err);
        check(rev_req_o == !b[2], "R7 reverse request level", rev_req_o, !b[2]);
        check_oe();
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(host_clk_o == 1'b1, "R1 strobe idle high", host_clk_o, 1);
        check(in_ready == 1'b1, "R1 ready", in_ready, 1);
        check(drv_pp_o == 1'b0, "R1 open-drain mode", drv_pp_o, 0);
        check(timeout_err_o == 1'b0, "R1 no error", timeout_err_o, 0);
        check(rev_req_o == 1'b0, "R1 no reverse request", rev_req_o, 0);
        check_oe();

        // R7 exact latency
        periph_req_n_i = 1'b0;
        @(negedge clk);
        check(rev_req_o == 1'b0, "R7 after one edge", rev_req_o, 0);
        @(negedge clk);
        check(rev_req_o == 1'b1, "R7 after two edges", rev_req_o, 1);
        periph_req_n_i = 1'b1;
        repeat (2) @(negedge clk);
        check(rev_req_o == 1'b0, "R7 release", rev_req_o, 0);

        // R6 busy peripheral blocks start
        periph_ack_i = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R6 ready one edge after ack", in_ready, 1);
        @(negedge clk);
        check(in_ready == 1'b0, "R6 ready drops", in_ready, 0);
        in_valid = 1'b1;
        in_data  = 8'hA5;
        repeat (3) begin
            @(negedge clk);
            check(host_clk_o == 1'b1, "R6 no strobe while busy", host_clk_o, 1);
            check(pd_o == 8'h00, "R6 bus untouched", pd_o, 0);
        end
        in_valid = 1'b0;
        periph_ack_i = 1'b0;
        repeat (2) @(negedge clk);
        check(in_ready == 1'b1, "R6 ready back", in_ready, 1);

        // R9 idle switch to push-pull and back
        ecp_mode_req = 1'b1;
        #1;
        check(in_ready == 1'b0, "R9 ready low while pending", in_ready, 0);
        @(negedge clk);
        check(drv_pp_o == 1'b0, "R9 mode after one edge", drv_pp_o, 0);
        check(host_clk_oe == 1'b0, "R10 open-drain idle enable", host_clk_oe, 0);
        @(negedge clk);
        check(drv_pp_o == 1'b1, "R9 mode after two edges", drv_pp_o, 1);
        check(host_clk_o == 1'b1, "R9 strobe steady", host_clk_o, 1);
        check_oe();
        @(negedge clk);
        check(in_ready == 1'b1, "R9 ready after switch", in_ready, 1);
        ecp_mode_req = 1'b0;
        repeat (3) @(negedge clk);
        check(drv_pp_o == 1'b0, "R9 back to open-drain", drv_pp_o, 0);
        check(in_ready == 1'b1, "R9 ready after return", in_ready, 1);

        // sweep: every setup length, ack delays around the watchdog limit
        for (int s = 0; s < 4; s++) begin
            for (int d = 0; d < 5; d++) begin
                for (int l = 0; l < 5; l++) begin
                    int k = s * 25 + d * 5 + l;
                    send(8'((k * 37 + 5) & 255), 1'((d + l) % 2), s, d, l,
                         (l == 2) && (d == 1));
                end
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule